// File: doc/BRIEF.md
# Soft-Mute Volume Ramp Controller

This block applies a per-channel gain to three audio channels (left, right and subwoofer) and moves that gain smoothly whenever a mute control changes. Each channel has its own 22-bit programmed volume. With the mute input low, the applied gain walks toward the programmed volume by a fixed step once per audio frame. With the mute input high, it walks toward zero at the same rate. The output is never cut or restored in one jump. Gain is unsigned fixed point with 20 fractional bits, so 1.0 is 0x100000. The step is 1/512 of that value, which means a channel sitting at 1.0 reaches silence in exactly 512 frames.

Every incoming sample is multiplied by the gain currently applied to its channel. The product is rounded, saturated to the sample width and registered. A run-enable input stands in for a soft power-down. While it is low, nothing advances and every stored value is kept. Only the synchronous reset clears the state.

Top module: `soft_mute_ramp`

## Requirements
- R1: After the synchronous active-high reset `rst`, all three applied gains are 0, `out_valid` is 0 and all three sample outputs are 0.
- R2: With `mute` low, each `frame_tick` cycle (with `run_en` high) moves a channel's gain toward its volume input by exactly 0x000800 (1/512 of 1.0 = 0x100000). The gain never passes the volume; it lands on the volume value. A gain that is above its volume steps down toward it in the same way. With no `frame_tick`, the gain does not change.
- R3: With `mute` high, each frame tick lowers the gain by 0x000800, clamped at 0. A gain of 0x100000 reaches 0 on exactly the 512th tick and is still nonzero after the 511th.
- R4: When `mute` is cleared, the gain ramps back up and stops exactly at the programmed volume (not at 1.0).
- R5: The three channels are independent. Each follows its own volume input, and `gain_*`/`out_*` for left, right and subwoofer correspond to `vol_*`/`smp_*` of the same name.
- R6: A change of a volume input during a ramp changes only the target. The gain continues from its current value with steps of at most 0x000800 and no jump.
- R7: Raising `mute` during an upward ramp reverses the direction starting from the current gain. The next tick gives the current gain minus 0x000800.
- R8: While `run_en` is low, frame ticks and samples are ignored. The gains and sample outputs hold their values and `out_valid` is 0.
- R9: A sample accepted with `in_valid` and `run_en` high gives `out_valid` high on the next cycle. The output is floor((smp × gain + 2^19) / 2^20): the sample is signed 24-bit, the gain is the value before that clock edge, and the result is saturated to the range [-0x800000, 0x7FFFFF].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Processing enable; low freezes all state |
| frame_tick | input | 1 | One-cycle strobe per audio frame |
| mute | input | 1 | Soft-mute request |
| vol_left | input | 22 | Programmed left volume, 1.0 = 0x100000 |
| vol_right | input | 22 | Programmed right volume |
| vol_sub | input | 22 | Programmed subwoofer volume |
| in_valid | input | 1 | Sample inputs are valid this cycle |
| smp_left | input | 24 | Left sample, signed |
| smp_right | input | 24 | Right sample, signed |
| smp_sub | input | 24 | Subwoofer sample, signed |
| gain_left | output | 22 | Applied left gain |
| gain_right | output | 22 | Applied right gain |
| gain_sub | output | 22 | Applied subwoofer gain |
| out_valid | output | 1 | Scaled samples valid |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| out_sub | output | 24 | Scaled subwoofer sample |

## Verification
The ramp is tried with four kinds of pattern:
- **Three volumes that differ**, one of them not a multiple of the step. This separates channel mixing from clamp errors.
- **A mute from exactly 1.0, counted frame by frame.** This shows an off-by-one in the step size or in the zero clamp.
- **Volume changes and mute flips in the middle of a ramp.** These show whether the gain jumps or restarts rather than continuing from its present value.
- **Samples at rounding midpoints and at full scale through a gain of 3.0.** These separate the rounding direction from the saturation.

A behavioural model compares every output on every cycle, including stretches with `run_en` low, where any movement is an error.

// File: rtl/smr_pkg.sv
package smr_pkg;
  // Channel indices in the order the top module uses them
  typedef enum logic [1:0] {
    CH_LEFT  = 2'd0,
    CH_RIGHT = 2'd1,
    CH_SUB   = 2'd2
  } smr_chan_e;

  localparam int SMR_NCH = 3;
endpackage

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp #(
  parameter int GAIN_W      = 22,
  parameter int FRAC_W      = 20,
  parameter int RAMP_FRAMES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              frame_tick,
  input  logic              mute,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] gain_q
);
  localparam int STEP_I = (1 << FRAC_W) / RAMP_FRAMES;
  localparam logic [GAIN_W:0] STEP = (GAIN_W + 1)'(STEP_I);

  logic [GAIN_W:0]   gain_x;
  logic [GAIN_W:0]   targ_x;
  logic [GAIN_W:0]   up_sum;
  logic [GAIN_W:0]   dn_lim;
  logic [GAIN_W-1:0] gain_d;
  logic              advance;

  assign gain_x  = {1'b0, gain_q};
  assign targ_x  = {1'b0, target};
  assign up_sum  = gain_x + STEP;
  assign dn_lim  = targ_x + STEP;
  assign advance = run_en && frame_tick;

  always_comb begin
    gain_d = gain_q;
    if (mute) begin
      if (gain_x >= STEP) gain_d = gain_q - STEP[GAIN_W-1:0];
      else                gain_d = '0;
    end else if (gain_q < target) begin
      if (up_sum >= targ_x) gain_d = target;
      else                  gain_d = up_sum[GAIN_W-1:0];
    end else if (gain_q > target) begin
      if (gain_x >= dn_lim) gain_d = gain_q - STEP[GAIN_W-1:0];
      else                  gain_d = target;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          gain_q <= '0;
    else if (advance) gain_q <= gain_d;
  end

  // R2 / R6: a frame never moves the gain by more than one step
  assert_step_bound_R6: assert property (@(posedge clk) disable iff (rst)
    advance |=> ((gain_q >= $past(gain_q)) ? ((gain_q - $past(gain_q)) <= STEP[GAIN_W-1:0])
                                           : (($past(gain_q) - gain_q) <= STEP[GAIN_W-1:0])));

  // R2 / R8: without an enabled frame tick the gain stays put
  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(gain_q));

  // R3: a muted frame never raises the gain
  assert_mute_down_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && mute) |=> (gain_q <= $past(gain_q)));

  // R4: an upward ramp never overshoots the target
  assert_no_overshoot_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !mute && (gain_q <= target)) |=> (gain_q <= $past(target)));

  // R7: mute during an upward ramp reverses from the current gain
  assert_reverse_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && mute && (gain_x >= STEP)) |=> (gain_q == $past(gain_q) - STEP[GAIN_W-1:0]));
endmodule

// File: rtl/smr_sample_scale.sv
module smr_sample_scale #(
  parameter int SAMP_W = 24,
  parameter int GAIN_W = 22,
  parameter int FRAC_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [SAMP_W-1:0] smp,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [SAMP_W-1:0] out_q
);
  localparam int PROD_W = SAMP_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] RND  = PROD_W'(64'sd1 <<< (FRAC_W - 1));
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((64'sd1 <<< (SAMP_W - 1)) - 64'sd1);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - PROD_W'(1);

  logic signed [PROD_W-1:0] smp_x;
  logic signed [PROD_W-1:0] gain_x;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic signed [SAMP_W-1:0] sat_d;

  assign smp_x   = PROD_W'(smp);
  assign gain_x  = signed'(PROD_W'(gain));
  assign prod    = smp_x * gain_x;
  assign shifted = (prod + RND) >>> FRAC_W;

  always_comb begin
    if (shifted > MAXV)      sat_d = MAXV[SAMP_W-1:0];
    else if (shifted < MINV) sat_d = MINV[SAMP_W-1:0];
    else                     sat_d = shifted[SAMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       out_q <= '0;
    else if (load) out_q <= sat_d;
  end

  // R9: zero gain always yields silence
  assert_zero_gain_R9: assert property (@(posedge clk) disable iff (rst)
    (load && (gain == '0)) |=> (out_q == '0));

  // R9: a positive sample through a positive gain never comes out negative
  assert_sign_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (load && !smp[SAMP_W-1]) |=> !out_q[SAMP_W-1]);

  // R8: output holds when nothing is loaded
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(out_q));
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int GAIN_W      = 22,
  parameter int FRAC_W      = 20,
  parameter int SAMP_W      = 24,
  parameter int RAMP_FRAMES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              frame_tick,
  input  logic              mute,
  input  logic [GAIN_W-1:0] vol_left,
  input  logic [GAIN_W-1:0] vol_right,
  input  logic [GAIN_W-1:0] vol_sub,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] smp_left,
  input  logic [SAMP_W-1:0] smp_right,
  input  logic [SAMP_W-1:0] smp_sub,
  output logic [GAIN_W-1:0] gain_left,
  output logic [GAIN_W-1:0] gain_right,
  output logic [GAIN_W-1:0] gain_sub,
  output logic              out_valid,
  output logic [SAMP_W-1:0] out_left,
  output logic [SAMP_W-1:0] out_right,
  output logic [SAMP_W-1:0] out_sub
);
  import smr_pkg::*;

  logic [GAIN_W-1:0]        vol_a  [SMR_NCH];
  logic [SAMP_W-1:0]        smp_a  [SMR_NCH];
  logic [GAIN_W-1:0]        gain_a [SMR_NCH];
  logic signed [SAMP_W-1:0] out_a  [SMR_NCH];
  logic                     load;

  assign vol_a[CH_LEFT]  = vol_left;
  assign vol_a[CH_RIGHT] = vol_right;
  assign vol_a[CH_SUB]   = vol_sub;
  assign smp_a[CH_LEFT]  = smp_left;
  assign smp_a[CH_RIGHT] = smp_right;
  assign smp_a[CH_SUB]   = smp_sub;
  assign load = in_valid && run_en;

  for (genvar c = 0; c < SMR_NCH; c++) begin : g_chan
    smr_gain_ramp #(
      .GAIN_W     (GAIN_W),
      .FRAC_W     (FRAC_W),
      .RAMP_FRAMES(RAMP_FRAMES)
    ) i_ramp (
      .clk       (clk),
      .rst       (rst),
      .run_en    (run_en),
      .frame_tick(frame_tick),
      .mute      (mute),
      .target    (vol_a[c]),
      .gain_q    (gain_a[c])
    );

    smr_sample_scale #(
      .SAMP_W(SAMP_W),
      .GAIN_W(GAIN_W),
      .FRAC_W(FRAC_W)
    ) i_scale (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .smp  (signed'(smp_a[c])),
      .gain (gain_a[c]),
      .out_q(out_a[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= load;
  end

  assign gain_left  = gain_a[CH_LEFT];
  assign gain_right = gain_a[CH_RIGHT];
  assign gain_sub   = gain_a[CH_SUB];
  assign out_left   = out_a[CH_LEFT];
  assign out_right  = out_a[CH_RIGHT];
  assign out_sub    = out_a[CH_SUB];

  // R9: valid follows an accepted sample by exactly one cycle
  assert_valid_lag_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && run_en) |=> out_valid);

  // R8: nothing is produced while processing is stopped
  assert_no_out_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !out_valid);
endmodule

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
  localparam int GW = 22;
  localparam int SW = 24;
  localparam longint ONE  = 64'h100000;
  localparam longint STEP = 64'h800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b1, frame_tick = 1'b0, mute = 1'b0, in_valid = 1'b0;
  logic [GW-1:0] vol_left = '0, vol_right = '0, vol_sub = '0;
  logic [SW-1:0] smp_left = '0, smp_right = '0, smp_sub = '0;
  logic [GW-1:0] gain_left, gain_right, gain_sub;
  logic out_valid;
  logic [SW-1:0] out_left, out_right, out_sub;

  always #4 clk = ~clk;

  soft_mute_ramp i_soft_mute_ramp (
    .clk(clk), .rst(rst), .run_en(run_en), .frame_tick(frame_tick), .mute(mute),
    .vol_left(vol_left), .vol_right(vol_right), .vol_sub(vol_sub),
    .in_valid(in_valid), .smp_left(smp_left), .smp_right(smp_right), .smp_sub(smp_sub),
    .gain_left(gain_left), .gain_right(gain_right), .gain_sub(gain_sub),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right), .out_sub(out_sub));

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  string phase = "R1";
  bit done = 1'b0;

  longint m_gain [3];
  longint m_out  [3];
  bit     m_valid;

  function automatic longint sx(input logic [SW-1:0] v);
    return longint'(signed'(v));
  endfunction

  function automatic longint scale(input longint s, input longint g);
    longint r;
    r = (s * g + (64'sd1 <<< 19)) >>> 20;
    if (r > 64'sd8388607)  r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r;
  endfunction

  function automatic longint step_gain(input longint g, input longint t, input bit m);
    if (m) return (g >= STEP) ? g - STEP : 0;
    if (g < t) return (g + STEP >= t) ? t : g + STEP;
    if (g > t) return (g >= t + STEP) ? g - STEP : t;
    return g;
  endfunction

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    longint tg [3];
    longint sm [3];
    tg[0] = longint'(vol_left); tg[1] = longint'(vol_right); tg[2] = longint'(vol_sub);
    sm[0] = sx(smp_left); sm[1] = sx(smp_right); sm[2] = sx(smp_sub);
    if (rst) begin
      for (int c = 0; c < 3; c++) begin m_gain[c] = 0; m_out[c] = 0; end
      m_valid = 0;
    end else begin
      m_valid = in_valid && run_en;
      for (int c = 0; c < 3; c++) begin
        if (in_valid && run_en) m_out[c] = scale(sm[c], m_gain[c]);
        if (frame_tick && run_en) m_gain[c] = step_gain(m_gain[c], tg[c], mute);
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      check(phase, "gain_left",  longint'(gain_left),  m_gain[0]);
      check(phase, "gain_right", longint'(gain_right), m_gain[1]);
      check(phase, "gain_sub",   longint'(gain_sub),   m_gain[2]);
      check(phase, "out_valid",  longint'(out_valid),  longint'(m_valid));
      check(phase, "out_left",   sx(out_left),  m_out[0]);
      check(phase, "out_right",  sx(out_right), m_out[1]);
      check(phase, "out_sub",    sx(out_sub),   m_out[2]);
    end
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic push(input longint l, input longint r, input longint s);
    @(negedge clk);
    smp_left = SW'(l); smp_right = SW'(r); smp_sub = SW'(s); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    int cnt;
    longint g0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "gain_left after reset", longint'(gain_left), 0);
    check("R1", "out_valid after reset", longint'(out_valid), 0);
    check("R1", "out_sub after reset", sx(out_sub), 0);

    // R2 R5: ramp up to distinct volumes, one off-grid
    phase = "R2";
    vol_left = 22'h100000; vol_right = 22'h080000 + 22'd1000; vol_sub = 22'h300000;
    repeat (5) @(negedge clk);
    check("R2", "no tick no change", longint'(gain_left), 0);
    frames(1);
    check("R2", "one step", longint'(gain_left), STEP);
    frames(1600);
    phase = "R5";
    check("R5", "left settles", longint'(gain_left), ONE);
    check("R5", "right clamps off-grid", longint'(gain_right), 64'h080000 + 1000);
    check("R5", "sub settles at 3.0", longint'(gain_sub), 64'h300000);

    // R9: rounding and saturation
    phase = "R9";
    push(3, 3, 64'sh7FFFFF);
    check("R9", "left 3*1.0", sx(out_left), 3);
    check("R9", "sub saturates high", sx(out_sub), 64'sh7FFFFF);
    push(-5, -7, -64'sh800000);
    check("R9", "sub saturates low", sx(out_sub), -64'sh800000);
    vol_right = 22'h080000;
    frames(1);
    push(3, 3, 0);
    check("R9", "right 3*0.5 rounds up", sx(out_right), 2);
    push(-3, -3, 0);
    check("R9", "right -3*0.5 rounds", sx(out_right), -1);

    // R3: mute from 1.0 takes exactly 512 frames
    phase = "R3";
    mute = 1'b1;
    cnt = 0;
    for (int i = 0; i < 600 && gain_left != 0; i++) begin
      frames(1);
      cnt++;
    end
    check("R3", "frames to silence from 1.0", cnt, 512);
    push(100000, 100000, 100000);
    check("R3", "muted output", sx(out_left), 0);

    // R4: unmute returns to programmed volume
    phase = "R4";
    mute = 1'b0;
    frames(1200);
    check("R4", "right back at 0.5", longint'(gain_right), 64'h080000);
    check("R4", "left back at 1.0", longint'(gain_left), ONE);

    // R6: volume change mid-ramp
    phase = "R6";
    mute = 1'b1; frames(100); mute = 1'b0; frames(20);
    g0 = longint'(gain_left);
    vol_left = 22'h040000;
    frames(1);
    check("R6", "no jump on target change", longint'(gain_left), g0 - STEP);
    frames(600);
    check("R6", "new target reached", longint'(gain_left), 64'h040000);

    // R7: mute during ramp-up reverses
    phase = "R7";
    mute = 1'b1; frames(300); mute = 1'b0; frames(10);
    g0 = longint'(gain_sub);
    mute = 1'b1;
    frames(1);
    check("R7", "reverse from current gain", longint'(gain_sub), g0 - STEP);
    mute = 1'b0;

    // R8: stopped processing ignores ticks and samples
    phase = "R8";
    frames(3);
    g0 = longint'(gain_right);
    run_en = 1'b0;
    frames(5);
    push(1000, 1000, 1000);
    check("R8", "gain held while stopped", longint'(gain_right), g0);
    check("R8", "no valid while stopped", longint'(out_valid), 0);
    run_en = 1'b1;
    frames(2);
    push(7, -9, 11);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule